// File: doc/BRIEF.md
# Indexed High-Byte-AND Store Unit

This unit produces the write address and write data for a family of indexed store operations. In these operations the stored byte is a register value masked by the base address high byte plus one. The CPU datapath presents a base address that has already been resolved, the index register contents, the A, X and Y register values and the opcode, and pulses `start`. One clock later the unit issues a single-cycle memory write. For the stack-loading variant, it also issues a single-cycle stack pointer load.

The low address byte is the base low byte plus the index. If that addition carries out of the low byte, the high byte of the write address is not the incremented base high byte. It is the stored data value itself, so the data corrupts the address. If there is no carry, the high byte is the base high byte unchanged. The incremented base high byte still masks the data in both cases.

The control is a two-state machine. In `ST_IDLE` no write is driven. The transition from `ST_IDLE` to `ST_STORE` is taken on `start` with a recognised opcode. `ST_STORE` drives the write strobe for one cycle. From `ST_STORE` the machine goes back to `ST_IDLE` when there is no new accepted start. It stays in `ST_STORE` when a recognised start arrives in the same cycle, which gives back-to-back writes. `start` with any other opcode leaves or returns the machine to `ST_IDLE`.

Top module: `hb_and_store`

## Requirements
- R1: Opcodes 0x93 and 0x9F write data (A & X & (base_hi + 1)), and the index is Y.
- R2: Opcode 0x9E writes data (X & (base_hi + 1)), and the index is Y.
- R3: Opcode 0x9C writes data (Y & (base_hi + 1)), and the index is X.
- R4: Opcode 0x9B pulses `sp_we` with `sp_val` = (A & X) and writes the same data as R1, with Y as the index. No other opcode asserts `sp_we`.
- R5: When base_lo + index does not carry, `wr_addr` equals {base_hi, (base_lo + index) mod 256}.
- R6: When base_lo + index carries, `wr_addr` equals {wr_data, (base_lo + index) mod 256}.
- R7: base_hi + 1 wraps modulo 256, so a base high byte of 0xFF masks the data to 0x00.
- R8: `wr_en` (and `sp_we` where it applies) is high in exactly the cycle after an accepted start, and returns low when no new start follows.
- R9: A start with any opcode other than 0x93, 0x9F, 0x9E, 0x9C or 0x9B causes neither `wr_en` nor `sp_we`.
- R10: During and right after reset, `wr_en`, `sp_we`, `wr_addr`, `wr_data` and `sp_val` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe for one store |
| opcode | input | 8 | Opcode selecting the variant |
| base_addr | input | 16 | Resolved base address before indexing |
| acc | input | 8 | Accumulator value |
| xr | input | 8 | X register value |
| yr | input | 8 | Y register value |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Effective write address |
| wr_data | output | 8 | Store data |
| sp_we | output | 1 | Stack pointer load enable |
| sp_val | output | 8 | Value to load into the stack pointer |

## Verification
The hardest case to reach is a page crossing where the masked data is neither zero nor equal to the incremented high byte. Only that case shows whether the address high byte really comes from the data rather than from base_hi + 1. Uniform random stimulus seldom produces such a case with a distinctive value. The random stimulus therefore biases the base low byte and the index towards large values, and it mixes in directed cases with a base high byte of 0xFF, where the mask wraps to zero.

// File: rtl/shstore_pkg.sv
package shstore_pkg;

    localparam logic [7:0] OPC_AXH_IND = 8'h93;
    localparam logic [7:0] OPC_AXH_ABS = 8'h9F;
    localparam logic [7:0] OPC_XH_ABS  = 8'h9E;
    localparam logic [7:0] OPC_YH_ABS  = 8'h9C;
    localparam logic [7:0] OPC_SPH_ABS = 8'h9B;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_AX,
        SRC_X,
        SRC_Y
    } src_sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_STORE
    } st_e;

    typedef struct packed {
        logic     valid;
        logic     idx_is_x;
        logic     sp_load;
        src_sel_e src;
    } dec_t;

endpackage

// File: rtl/sh_op_decode.sv
module sh_op_decode
    import shstore_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    always_comb begin
        dec = '{valid: 1'b0, idx_is_x: 1'b0, sp_load: 1'b0, src: SRC_NONE};
        case (opcode)
            OPC_AXH_IND, OPC_AXH_ABS: begin
                dec.valid = 1'b1;
                dec.src   = SRC_AX;
            end
            OPC_XH_ABS: begin
                dec.valid = 1'b1;
                dec.src   = SRC_X;
            end
            OPC_YH_ABS: begin
                dec.valid    = 1'b1;
                dec.src      = SRC_Y;
                dec.idx_is_x = 1'b1;
            end
            OPC_SPH_ABS: begin
                dec.valid   = 1'b1;
                dec.src     = SRC_AX;
                dec.sp_load = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sh_addr_gen.sv
module sh_addr_gen #(
    parameter int DATA_W = 8
) (
    input  logic [2*DATA_W-1:0] base,
    input  logic [DATA_W-1:0]   index,
    input  logic [DATA_W-1:0]   src_val,
    output logic [2*DATA_W-1:0] addr,
    output logic [DATA_W-1:0]   data
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [DATA_W-1:0] base_lo;
    logic [DATA_W-1:0] base_hi;
    logic [DATA_W-1:0] hi_inc;
    logic [DATA_W:0]   lo_sum;
    logic              carry;

    assign base_lo = base[DATA_W-1:0];
    assign base_hi = base[ADDR_W-1:DATA_W];

    // wraps at the byte width: all ones becomes zero
    assign hi_inc  = base_hi + DATA_W'(1);
    assign lo_sum  = {1'b0, base_lo} + {1'b0, index};
    assign carry   = lo_sum[DATA_W];
    assign data    = src_val & hi_inc;

    // on a carry the data byte takes the place of the high byte
    assign addr = carry ? {data, lo_sum[DATA_W-1:0]}
                        : {base_hi, lo_sum[DATA_W-1:0]};

endmodule

// File: rtl/hb_and_store.sv
module hb_and_store
    import shstore_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [7:0]          opcode,
    input  logic [2*DATA_W-1:0] base_addr,
    input  logic [DATA_W-1:0]   acc,
    input  logic [DATA_W-1:0]   xr,
    input  logic [DATA_W-1:0]   yr,
    output logic                wr_en,
    output logic [2*DATA_W-1:0] wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic                sp_we,
    output logic [DATA_W-1:0]   sp_val
);

    localparam int ADDR_W = 2 * DATA_W;

    dec_t                dec;
    st_e                 state_q;
    st_e                 state_d;
    logic                accept;
    logic [DATA_W-1:0]   idx_val;
    logic [DATA_W-1:0]   src_val;
    logic [DATA_W-1:0]   ax_and;
    logic [ADDR_W-1:0]   nxt_addr;
    logic [DATA_W-1:0]   nxt_data;

    sh_op_decode i_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    assign ax_and  = acc & xr;
    assign idx_val = dec.idx_is_x ? xr : yr;

    always_comb begin
        unique case (dec.src)
            SRC_AX:   src_val = ax_and;
            SRC_X:    src_val = xr;
            SRC_Y:    src_val = yr;
            default:  src_val = '0;
        endcase
    end

    sh_addr_gen #(.DATA_W(DATA_W)) i_agen (
        .base    (base_addr),
        .index   (idx_val),
        .src_val (src_val),
        .addr    (nxt_addr),
        .data    (nxt_data)
    );

    assign accept = start && dec.valid;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = accept ? ST_STORE : ST_IDLE;
            ST_STORE: state_d = accept ? ST_STORE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign wr_en = (state_q == ST_STORE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            sp_we   <= 1'b0;
            sp_val  <= '0;
        end else begin
            sp_we <= accept && dec.sp_load;
            if (accept) begin
                wr_addr <= nxt_addr;
                wr_data <= nxt_data;
            end
            if (accept && dec.sp_load) begin
                sp_val <= ax_and;
            end
        end
    end

    // opcode membership recomputed from the port, independent of the decoder
    logic port_is_sh;
    assign port_is_sh = (opcode == 8'h93) || (opcode == 8'h9F) || (opcode == 8'h9E)
                     || (opcode == 8'h9C) || (opcode == 8'h9B);

    AST_STORE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start && port_is_sh |=> wr_en) else $error("store pulse missing"); // R8

    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        start && !port_is_sh |=> !wr_en && !sp_we) else $error("foreign opcode wrote"); // R9

    AST_SP_ONLY_STACK_OP: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we |-> wr_en && ($past(opcode) == 8'h9B)) else $error("stray sp load"); // R4

    AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_data & ~DATA_W'($past(base_addr[ADDR_W-1:DATA_W]) + DATA_W'(1))) == '0))
        else $error("data escapes mask"); // R7

    AST_HIGH_BYTE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[ADDR_W-1:DATA_W] == $past(base_addr[ADDR_W-1:DATA_W]))
               || (wr_addr[ADDR_W-1:DATA_W] == wr_data))
        else $error("bad high byte"); // R6

endmodule

// File: tb/test_hb_and_store.sv
module test_hb_and_store;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] base_addr = 16'h0000;
    logic [7:0]  acc = 8'h00, xr = 8'h00, yr = 8'h00;
    logic        wr_en, sp_we;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data, sp_val;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hb_and_store i_hb_and_store (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .base_addr(base_addr), .acc(acc), .xr(xr), .yr(yr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sp_we(sp_we), .sp_val(sp_val)
    );

    function automatic bit is_sh(input logic [7:0] op);
        return op == 8'h93 || op == 8'h9F || op == 8'h9E || op == 8'h9C || op == 8'h9B;
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] op, input logic [15:0] b,
                                            input logic [7:0] a, input logic [7:0] x,
                                            input logic [7:0] y);
        logic [7:0] m;
        m = b[15:8] + 8'd1;
        case (op)
            8'h9E:   return x & m;
            8'h9C:   return y & m;
            default: return a & x & m;
        endcase
    endfunction

    function automatic logic [15:0] exp_addr(input logic [7:0] op, input logic [15:0] b,
                                             input logic [7:0] a, input logic [7:0] x,
                                             input logic [7:0] y);
        logic [8:0] s;
        s = {1'b0, b[7:0]} + {1'b0, (op == 8'h9C) ? x : y};
        if (s[8]) return {exp_data(op, b, a, x, y), s[7:0]};
        return {b[15:8], s[7:0]};
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h93, 8'h9F: return "R1";
            8'h9E:        return "R2";
            8'h9C:        return "R3";
            8'h9B:        return "R4";
            default:      return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [15:0] b,
                          input logic [7:0] a, input logic [7:0] x, input logic [7:0] y);
        logic [8:0] s;
        string t;
        t = tag_of(op);
        s = {1'b0, b[7:0]} + {1'b0, (op == 8'h9C) ? x : y};
        @(negedge clk);
        start = 1'b1; opcode = op; base_addr = b; acc = a; xr = x; yr = y;
        @(negedge clk);
        start = 1'b0;
        check(is_sh(op) ? "R8" : "R9", "wr_en", 16'(wr_en), 16'(is_sh(op)));
        check(is_sh(op) ? "R4" : "R9", "sp_we", 16'(sp_we), 16'(op == 8'h9B));
        if (is_sh(op)) begin
            check(t, "wr_data", 16'(wr_data), 16'(exp_data(op, b, a, x, y)));
            check(s[8] ? "R6" : "R5", "wr_addr", wr_addr, exp_addr(op, b, a, x, y));
            if (op == 8'h9B) check("R4", "sp_val", 16'(sp_val), 16'(a & x));
        end
        @(negedge clk);
        check("R8", "wr_en drop", 16'(wr_en), 16'h0);
        check("R8", "sp_we drop", 16'(sp_we), 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [5];
        ops = '{8'h93, 8'h9F, 8'h9E, 8'h9C, 8'h9B};
        repeat (3) @(negedge clk);
        check("R10", "wr_en reset", 16'(wr_en), 16'h0);
        check("R10", "sp_we reset", 16'(sp_we), 16'h0);
        check("R10", "wr_addr reset", wr_addr, 16'h0);
        check("R10", "wr_data reset", 16'(wr_data), 16'h0);
        check("R10", "sp_val reset", 16'(sp_val), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "wr_en after reset", 16'(wr_en), 16'h0);

        // directed corner cases
        run_op(8'h93, 16'h12F0, 8'hFF, 8'h3F, 8'h20);  // R1 crossing, R6
        run_op(8'h9F, 16'h4000, 8'hFF, 8'hFF, 8'h05);  // R1 no crossing, R5
        run_op(8'h9E, 16'hFF80, 8'h00, 8'hFF, 8'h90);  // R2 and R7 wrap
        run_op(8'h9C, 16'h0AF8, 8'h00, 8'h10, 8'hFF);  // R3 crossing, X index
        run_op(8'h9C, 16'hFF00, 8'h00, 8'h01, 8'hFF);  // R7 no crossing
        run_op(8'h9B, 16'h7EC0, 8'hF7, 8'h7F, 8'h60);  // R4 with crossing
        run_op(8'h8D, 16'h12F0, 8'hFF, 8'hFF, 8'hFF);  // R9 foreign opcode
        run_op(8'h00, 16'hFFFF, 8'hFF, 8'hFF, 8'hFF);  // R9 foreign opcode

        // constrained random
        void'($urandom(32'd20240));
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            logic [15:0] b;
            logic [7:0] a, x, y;
            op = ($urandom % 8 == 0) ? 8'($urandom) : ops[$urandom % 5];
            b  = 16'($urandom);
            if ($urandom % 2 == 0) b[7:6] = 2'b11;
            if ($urandom % 6 == 0) b[15:8] = 8'hFF;
            a = 8'($urandom); x = 8'($urandom); y = 8'($urandom);
            if ($urandom % 2 == 0) begin
                x[7] = 1'b1; y[7] = 1'b1;
            end
            run_op(op, b, a, x, y);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule